// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output-compare channel of a general-purpose timer. An external counter supplies its running count, its counting direction, a count-enable strobe and an update-event strobe. The channel compares that count against a 16-bit compare value written by software. A 3-bit mode selects one of eight behaviours that drive an active-high reference signal. The pin output is that reference, inverted when the polarity bit is set.

The compare value has two register stages: a buffer that software writes and an active register that the comparator uses. When preload is off, a write goes straight into the active register. When preload is on, the active register takes the buffer contents only on an update event. In the two PWM modes the reference level follows the comparison, with a separate rule for each counting direction. It changes only when the comparison outcome changes, or when the channel enters a PWM mode directly from frozen mode.

This channel has no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake. Mode, preload and polarity are level inputs held by the timer's register block. The compare value arrives through a one-cycle write strobe.

Top module: `oc_channel`

## Requirements
- R1: After reset the reference and the pin output (with polarity 0) are low, and both compare registers hold 0.
- R2: In mode 3'b000 (frozen) the reference keeps its value whatever the counter does.
- R3: On an evaluating cycle in which counter equals the active compare value, the reference is set high by mode 3'b001, cleared low by mode 3'b010 and inverted by mode 3'b011. The new value is visible after that clock edge, and it is inverted again on every further matching cycle.
- R4: On an evaluating cycle, mode 3'b100 drives the reference low and mode 3'b101 drives it high, whatever the counter value.
- R5: Mode 3'b110 (PWM 1) gives a high reference while counter < compare when counting up (count_down = 0), and while counter <= compare when counting down.
- R6: Mode 3'b111 (PWM 2) gives the complement of R5 in both directions.
- R7: In a PWM mode the reference is rewritten only when the raw comparison outcome differs from the previous evaluating cycle, or when the previous evaluating cycle ran in mode 3'b000. Otherwise it keeps its earlier value, including one left by a force mode.
- R8: With preload_en = 0, a write reaches the active compare register at the write edge and is used on the next evaluating cycle. cmp_rd_data returns the active register.
- R9: With preload_en = 1, writes reach only the buffer, and cmp_rd_data returns the buffer. The active register loads the buffer on each upd_evt pulse and holds its value otherwise.
- R10: oc_pin equals oc_ref when pol_inv = 0 and its inverse when pol_inv = 1, without a clock delay.
- R11: A cycle evaluates only when cnt_en = 1 and dir_is_in = 0. On any other cycle the reference holds its value in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter advanced this cycle; compare is evaluated |
| cnt_val | input | 16 | Current counter value |
| cnt_down | input | 1 | 1 = counter counting down |
| upd_evt | input | 1 | Update-event pulse from the counter |
| cmp_wr_en | input | 1 | Compare value write strobe |
| cmp_wr_data | input | 16 | Compare value to write |
| cmp_rd_data | output | 16 | Compare value read back |
| mode_sel | input | 3 | Compare behaviour selector |
| preload_en | input | 1 | 1 = buffered compare writes |
| pol_inv | input | 1 | 1 = pin output is the inverted reference |
| dir_is_in | input | 1 | 1 = channel configured as input; mode ignored |
| oc_ref | output | 1 | Active-high internal reference |
| oc_pin | output | 1 | Polarity-adjusted output |

## Verification
The reference is registered. A change caused by the inputs of one evaluating cycle shows on oc_ref and oc_pin right after that cycle's rising edge. oc_pin also follows pol_inv with no clock delay. A compare write lands in the active register at its own edge and first affects the reference on the following evaluating edge. With preload on, the update pulse plays that role instead. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and samples at the next falling edge, so every expected value is compared at the one sample point where it first becomes due.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OCM_FROZEN = 3'b000,
    OCM_SET    = 3'b001,
    OCM_CLR    = 3'b010,
    OCM_TOG    = 3'b011,
    OCM_LOW    = 3'b100,
    OCM_HIGH   = 3'b101,
    OCM_PWM_A  = 3'b110,
    OCM_PWM_B  = 3'b111
  } oc_mode_e;
endpackage

// File: rtl/oc_cmp_reg.sv
module oc_cmp_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         preload_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         upd_evt,
  output logic [W-1:0] act_q,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] buf_q;

  // The buffer always captures writes; the active register takes either the
  // write directly or the buffer on an update event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_en) buf_q <= wr_data;
      if (!preload_en && wr_en) act_q <= wr_data;
      else if (preload_en && upd_evt) act_q <= buf_q;
    end
  end

  assign rd_data = preload_en ? buf_q : act_q;

  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_en && wr_en) |=> (act_q == $past(wr_data))); // R8
  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && !upd_evt) |=> $stable(act_q)); // R9
  AST_UPDATE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && upd_evt) |=> (act_q == $past(buf_q))); // R9
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         dir_is_in,
  input  logic [2:0]   mode_sel,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_down,
  input  logic [W-1:0] cmp_val,
  output logic         ref_q
);
  oc_mode_e mode;
  oc_mode_e prev_mode_q;
  logic     eval;
  logic     hit;
  logic     below;
  logic     below_prev_q;
  logic     pwm_fire;
  logic     ref_nxt;

  assign mode  = oc_mode_e'(mode_sel);
  assign eval  = cnt_en && !dir_is_in;
  assign hit   = (cnt_val == cmp_val);
  // Raw comparison: PWM 1 level, direction aware.
  assign below = cnt_down ? (cnt_val <= cmp_val) : (cnt_val < cmp_val);
  assign pwm_fire = (below != below_prev_q) || (prev_mode_q == OCM_FROZEN);

  always_comb begin
    ref_nxt = ref_q;
    unique case (mode)
      OCM_FROZEN: ref_nxt = ref_q;
      OCM_SET:    if (hit) ref_nxt = 1'b1;
      OCM_CLR:    if (hit) ref_nxt = 1'b0;
      OCM_TOG:    if (hit) ref_nxt = ~ref_q;
      OCM_LOW:    ref_nxt = 1'b0;
      OCM_HIGH:   ref_nxt = 1'b1;
      OCM_PWM_A:  if (pwm_fire) ref_nxt = below;
      OCM_PWM_B:  if (pwm_fire) ref_nxt = ~below;
      default:    ref_nxt = ref_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q        <= 1'b0;
      below_prev_q <= 1'b0;
      prev_mode_q  <= OCM_FROZEN;
    end else if (eval) begin
      ref_q        <= ref_nxt;
      below_prev_q <= below;
      prev_mode_q  <= mode;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_en && !dir_is_in) |=> $stable(ref_q)); // R11
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !dir_is_in && mode_sel == 3'b000) |=> $stable(ref_q)); // R2
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !dir_is_in && mode_sel == 3'b101) |=> ref_q); // R4
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !dir_is_in && mode_sel == 3'b100) |=> !ref_q); // R4
  AST_SET_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !dir_is_in && mode_sel == 3'b001 && cnt_val == cmp_val) |=> ref_q); // R3
endmodule

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic             upd_evt,
  input  logic             cmp_wr_en,
  input  logic [CNT_W-1:0] cmp_wr_data,
  output logic [CNT_W-1:0] cmp_rd_data,
  input  logic [2:0]       mode_sel,
  input  logic             preload_en,
  input  logic             pol_inv,
  input  logic             dir_is_in,
  output logic             oc_ref,
  output logic             oc_pin
);
  logic [CNT_W-1:0] cmp_act;

  oc_cmp_reg #(.W(CNT_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .preload_en (preload_en),
    .wr_en      (cmp_wr_en),
    .wr_data    (cmp_wr_data),
    .upd_evt    (upd_evt),
    .act_q      (cmp_act),
    .rd_data    (cmp_rd_data)
  );

  oc_ref_gen #(.W(CNT_W)) u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .dir_is_in (dir_is_in),
    .mode_sel  (mode_sel),
    .cnt_val   (cnt_val),
    .cnt_down  (cnt_down),
    .cmp_val   (cmp_act),
    .ref_q     (oc_ref)
  );

  assign oc_pin = oc_ref ^ pol_inv;
endmodule

// File: tb/oc_channel_tb_top.sv
module oc_channel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en;
  logic [15:0] cnt_val;
  logic        cnt_down;
  logic        upd_evt;
  logic        cmp_wr_en;
  logic [15:0] cmp_wr_data;
  logic [15:0] cmp_rd_data;
  logic [2:0]  mode_sel;
  logic        preload_en;
  logic        pol_inv;
  logic        dir_is_in;
  logic        oc_ref;
  logic        oc_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oc_channel #(.CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_val(cnt_val),
    .cnt_down(cnt_down), .upd_evt(upd_evt), .cmp_wr_en(cmp_wr_en),
    .cmp_wr_data(cmp_wr_data), .cmp_rd_data(cmp_rd_data), .mode_sel(mode_sel),
    .preload_en(preload_en), .pol_inv(pol_inv), .dir_is_in(dir_is_in),
    .oc_ref(oc_ref), .oc_pin(oc_pin)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One evaluating cycle with the given mode and counter state.
  task automatic eval(logic [2:0] m, logic [15:0] c, logic dn);
    mode_sel = m; cnt_val = c; cnt_down = dn; cnt_en = 1'b1;
    step();
    cnt_en = 1'b0;
  endtask

  task automatic wr_cmp(logic [15:0] v);
    cmp_wr_en = 1'b1; cmp_wr_data = v;
    step();
    cmp_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ref", 16'(oc_ref), 16'd0);
    chk("R1 pin", 16'(oc_pin), 16'd0);
    chk("R1 cmp", cmp_rd_data, 16'd0);
  endtask

  task automatic t_frozen();
    wr_cmp(16'd5);
    eval(3'b000, 16'd5, 1'b0);
    chk("R2 frozen match", 16'(oc_ref), 16'd0);
  endtask

  task automatic t_match_modes();
    eval(3'b001, 16'd6, 1'b0); chk("R3 set no match", 16'(oc_ref), 16'd0);
    eval(3'b001, 16'd5, 1'b0); chk("R3 set match", 16'(oc_ref), 16'd1);
    eval(3'b010, 16'd6, 1'b0); chk("R3 clr no match", 16'(oc_ref), 16'd1);
    eval(3'b010, 16'd5, 1'b0); chk("R3 clr match", 16'(oc_ref), 16'd0);
    eval(3'b011, 16'd5, 1'b0); chk("R3 toggle 1", 16'(oc_ref), 16'd1);
    eval(3'b011, 16'd5, 1'b0); chk("R3 toggle 2", 16'(oc_ref), 16'd0);
    eval(3'b011, 16'd6, 1'b0); chk("R3 toggle no match", 16'(oc_ref), 16'd0);
  endtask

  task automatic t_force_and_gate();
    eval(3'b101, 16'd0, 1'b0); chk("R4 force high", 16'(oc_ref), 16'd1);
    eval(3'b100, 16'd5, 1'b0); chk("R4 force low", 16'(oc_ref), 16'd0);
    mode_sel = 3'b101; cnt_en = 1'b0; step();
    chk("R11 no cnt_en", 16'(oc_ref), 16'd0);
    dir_is_in = 1'b1; cnt_en = 1'b1; step();
    chk("R11 input dir", 16'(oc_ref), 16'd0);
    dir_is_in = 1'b0; step(); cnt_en = 1'b0;
    chk("R11 output dir", 16'(oc_ref), 16'd1);
  endtask

  task automatic t_polarity();
    pol_inv = 1'b1; #1;
    chk("R10 inverted", 16'(oc_pin), 16'd0);
    pol_inv = 1'b0; #1;
    chk("R10 plain", 16'(oc_pin), 16'd1);
  endtask

  task automatic t_pwm1();
    wr_cmp(16'd10);
    eval(3'b000, 16'd3, 1'b0);
    eval(3'b110, 16'd3, 1'b0);  chk("R5 up entry", 16'(oc_ref), 16'd1);
    eval(3'b110, 16'd9, 1'b0);  chk("R5 up below", 16'(oc_ref), 16'd1);
    eval(3'b110, 16'd10, 1'b0); chk("R5 up equal", 16'(oc_ref), 16'd0);
    eval(3'b110, 16'd11, 1'b0); chk("R5 up above", 16'(oc_ref), 16'd0);
    eval(3'b110, 16'd11, 1'b1); chk("R5 down above", 16'(oc_ref), 16'd0);
    eval(3'b110, 16'd10, 1'b1); chk("R5 down equal", 16'(oc_ref), 16'd1);
    eval(3'b110, 16'd3, 1'b1);  chk("R5 down below", 16'(oc_ref), 16'd1);
  endtask

  task automatic t_pwm2();
    wr_cmp(16'd10);
    eval(3'b000, 16'd3, 1'b0);
    eval(3'b111, 16'd3, 1'b0);  chk("R6 up below", 16'(oc_ref), 16'd0);
    eval(3'b111, 16'd10, 1'b0); chk("R6 up equal", 16'(oc_ref), 16'd1);
    eval(3'b111, 16'd11, 1'b1); chk("R6 down above", 16'(oc_ref), 16'd1);
    eval(3'b111, 16'd10, 1'b1); chk("R6 down equal", 16'(oc_ref), 16'd0);
  endtask

  task automatic t_pwm_hold();
    wr_cmp(16'd10);
    eval(3'b101, 16'd20, 1'b0);
    eval(3'b110, 16'd20, 1'b0); chk("R7 no change keeps force", 16'(oc_ref), 16'd1);
    eval(3'b110, 16'd5, 1'b0);  chk("R7 change to below", 16'(oc_ref), 16'd1);
    eval(3'b110, 16'd15, 1'b0); chk("R7 change to above", 16'(oc_ref), 16'd0);
  endtask

  task automatic t_direct();
    eval(3'b100, 16'd0, 1'b0);
    wr_cmp(16'd7);
    chk("R8 read active", cmp_rd_data, 16'd7);
    eval(3'b001, 16'd7, 1'b0); chk("R8 immediate use", 16'(oc_ref), 16'd1);
  endtask

  task automatic t_preload();
    wr_cmp(16'd10);
    eval(3'b100, 16'd0, 1'b0);
    preload_en = 1'b1;
    wr_cmp(16'd20);
    chk("R9 read buffer", cmp_rd_data, 16'd20);
    eval(3'b001, 16'd20, 1'b0); chk("R9 old value active", 16'(oc_ref), 16'd0);
    upd_evt = 1'b1; step(); upd_evt = 1'b0;
    eval(3'b001, 16'd20, 1'b0); chk("R9 after update", 16'(oc_ref), 16'd1);
    wr_cmp(16'd30);
    preload_en = 1'b0; #1;
    chk("R8 read shows active", cmp_rd_data, 16'd20);
  endtask

  initial begin
    rst_n = 1'b0; cnt_en = 0; cnt_val = 0; cnt_down = 0; upd_evt = 0;
    cmp_wr_en = 0; cmp_wr_data = 0; mode_sel = 0; preload_en = 0;
    pol_inv = 0; dir_is_in = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_frozen();
    t_match_modes();
    t_force_and_gate();
    t_polarity();
    t_pwm1();
    t_pwm2();
    t_pwm_hold();
    t_direct();
    t_preload();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule